// File: doc/BRIEF.md
# Output Fault Protection Controller

This block supervises one output channel of a switching regulator. It receives digitized samples of the output sense voltage and of the feedback node, together with a reference code. Every threshold is derived from that reference code. From these inputs it decides whether the high-side switch may be driven, whether the low-side switch must be forced on, whether switching must be inhibited, and whether the power-good logic must see a fault.

Two protections run side by side. The first is an over-voltage guard. When the sense sample stays above 1.2 times the reference for a qualification window, the guard removes the high-side permit. It then holds the low-side switch on until the output has discharged below the lower power-good level, and after that it keeps the high side off until the channel is re-enabled or the supply-ready input is cycled. The second is an open-loop guard. It arms once the output has come up, trips when the feedback collapses while the output still looks healthy, and recovers on its own with hysteresis.

Top module: `ofp_ctrl`

## Requirements
- R1: Thresholds are shift-and-add sums of the reference code R. The sums are: over-voltage = R + R/8 + R/16 + R/128 + R/256, upper = R/2 + R/4 + R/16 + R/32 + R/256 + R/512, lower = R/2 + R/4 + R/32 + R/64 + R/512 + R/1024, release = R/2 + R/4, trip = R/2 + R/8 + R/16 + R/128 + R/256. For R = 1024 these come to 1228, 870, 819, 768 and 716.
- R2: Sense and feedback codes are compared only in cycles where sample_valid is high. Values presented without the strobe have no effect.
- R3: Over-voltage means sense strictly greater than the over-voltage threshold. The guard trips after the condition has held for QUAL_CYC clock cycles (CLK_FREQ_HZ scaled to OV_QUAL_NS). A strobed sample that is not over restarts the window.
- R4: When the over-voltage guard trips, hs_permit goes low, ls_force_on goes high and pg_fault goes high, all at the same clock edge.
- R5: ls_force_on stays high until a strobed sense sample falls strictly below the lower threshold, and then goes low. pg_fault stays high.
- R6: After an over-voltage trip, hs_permit stays low until enable or supply_ok is deasserted and then reasserted.
- R7: The open-loop guard arms on a strobed sense sample strictly above the upper threshold. It disarms on a strobed sense sample not above the lower threshold.
- R8: While armed, a strobed feedback sample strictly below the trip threshold raises sw_disable and pg_fault.
- R9: sw_disable clears on a strobed feedback sample strictly above the release threshold, with no enable or supply cycle.
- R10: A low feedback sample while the guard is not armed has no effect.
- R11: When enable or supply_ok is low, all internal state is cleared, including the over-voltage latch and the armed state. One cycle later all four outputs are low.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable |
| supply_ok | input | 1 | Supply-ready indication |
| sample_valid | input | 1 | Strobe qualifying sense_code and fb_code |
| sense_code | input | CODE_W | Digitized output sense voltage |
| fb_code | input | CODE_W | Digitized feedback voltage |
| ref_code | input | CODE_W | Reference code that sets all thresholds |
| hs_permit | output | 1 | High-side drive allowed |
| ls_force_on | output | 1 | Request to hold the low-side switch on |
| sw_disable | output | 1 | Switching inhibited by the open-loop guard |
| pg_fault | output | 1 | Fault flag that forces power-good low |

## Verification
The bench probes each threshold at its exact code, such as sense equal to 1228 and feedback equal to 716. A design that used a non-strict compare, or a wrong shift term, would trip there or fail to trip one code beyond. The over-voltage window is interrupted by a sample below the threshold. A counter that did not restart would shut the high side off early. After a trip, the bench walks the output down through the lower threshold and then cycles enable and supply separately. A latch that released on its own, or that survived a re-enable, shows up as a wrong hs_permit. Finally, a low feedback sample is applied after a re-enable. A design that kept the armed state across the disable would raise sw_disable there.

// File: rtl/ofp_pkg.sv
package ofp_pkg;
  typedef enum logic [1:0] {
    OV_RUN   = 2'd0,
    OV_HOLD  = 2'd1,
    OV_LATCH = 2'd2
  } ovp_state_e;

  // Threshold multipliers as masks of right-shift terms (bit k adds ref>>k)
  localparam logic [15:0] MASK_OV    = 16'b0000_0001_1001_1001; // ~1.199
  localparam logic [15:0] MASK_UPPER = 16'b0000_0011_0011_0110; // ~0.850
  localparam logic [15:0] MASK_LOWER = 16'b0000_0110_0110_0110; // ~0.800
  localparam logic [15:0] MASK_REL   = 16'b0000_0000_0000_0110; //  0.750
  localparam logic [15:0] MASK_TRIP  = 16'b0000_0001_1001_1010; // ~0.699
endpackage

// File: rtl/ofp_thresh.sv
module ofp_thresh #(
  parameter int CODE_W = 12,
  localparam int TH_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ref_code,
  output logic [TH_W-1:0]   th_ov,
  output logic [TH_W-1:0]   th_upper,
  output logic [TH_W-1:0]   th_lower,
  output logic [TH_W-1:0]   th_rel,
  output logic [TH_W-1:0]   th_trip
);
  import ofp_pkg::*;

  localparam int NTH = 5;
  localparam logic [15:0] MASKS [NTH] = '{MASK_OV, MASK_UPPER, MASK_LOWER, MASK_REL, MASK_TRIP};

  logic [TH_W-1:0] th_q [NTH];

  function automatic logic [TH_W-1:0] shift_sum(input logic [CODE_W-1:0] r, input logic [15:0] m);
    logic [TH_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < 16; k++) begin
      if (m[k]) acc = acc + TH_W'(r >> k);
    end
    return acc;
  endfunction

  for (genvar g = 0; g < NTH; g++) begin : g_th
    always_ff @(posedge clk) begin
      if (rst) th_q[g] <= '0;
      else     th_q[g] <= shift_sum(ref_code, MASKS[g]);
    end
  end

  assign th_ov    = th_q[0];
  assign th_upper = th_q[1];
  assign th_lower = th_q[2];
  assign th_rel   = th_q[3];
  assign th_trip  = th_q[4];
endmodule

// File: rtl/ofp_ovp.sv
module ofp_ovp #(
  parameter int CODE_W   = 12,
  parameter int QUAL_CYC = 200,
  localparam int TH_W    = CODE_W + 1,
  localparam int CNT_W   = $clog2(QUAL_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              strobe,
  input  logic [CODE_W-1:0] sense,
  input  logic [TH_W-1:0]   th_ov,
  input  logic [TH_W-1:0]   th_lower,
  output logic              ovp_off,
  output logic              ls_hold
);
  import ofp_pkg::*;

  ovp_state_e       state;
  logic             ov_above;
  logic [CNT_W-1:0] cnt;
  logic             over_now;
  logic             below_low;

  assign over_now  = TH_W'(sense) > th_ov;
  assign below_low = TH_W'(sense) < th_lower;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      state    <= OV_RUN;
      ov_above <= 1'b0;
      cnt      <= '0;
    end else begin
      case (state)
        OV_RUN: begin
          if (strobe && !over_now) begin
            ov_above <= 1'b0;
            cnt      <= '0;
          end else begin
            if (strobe) ov_above <= 1'b1;
            if (ov_above) begin
              if (cnt == CNT_W'(QUAL_CYC - 1)) begin
                state    <= OV_HOLD;
                ov_above <= 1'b0;
                cnt      <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        end
        OV_HOLD: begin
          if (strobe && below_low) state <= OV_LATCH;
        end
        default: state <= OV_LATCH;
      endcase
    end
  end

  assign ovp_off = (state != OV_RUN);
  assign ls_hold = (state == OV_HOLD);
endmodule

// File: rtl/ofp_oflp.sv
module ofp_oflp #(
  parameter int CODE_W = 12,
  localparam int TH_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              strobe,
  input  logic [CODE_W-1:0] sense,
  input  logic [CODE_W-1:0] fb,
  input  logic [TH_W-1:0]   th_upper,
  input  logic [TH_W-1:0]   th_lower,
  input  logic [TH_W-1:0]   th_rel,
  input  logic [TH_W-1:0]   th_trip,
  output logic              armed,
  output logic              tripped
);
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      armed   <= 1'b0;
      tripped <= 1'b0;
    end else if (strobe) begin
      if (!armed && (TH_W'(sense) > th_upper))       armed <= 1'b1;
      else if (armed && !(TH_W'(sense) > th_lower))  armed <= 1'b0;

      if (!tripped && armed && (TH_W'(fb) < th_trip)) tripped <= 1'b1;
      else if (tripped && (TH_W'(fb) > th_rel))       tripped <= 1'b0;
    end
  end
endmodule

// File: rtl/ofp_ctrl.sv
module ofp_ctrl #(
  parameter int CODE_W      = 12,
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int OV_QUAL_NS  = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              supply_ok,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] sense_code,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] ref_code,
  output logic              hs_permit,
  output logic              ls_force_on,
  output logic              sw_disable,
  output logic              pg_fault
);
  localparam int TH_W     = CODE_W + 1;
  localparam int QUAL_RAW = (CLK_FREQ_HZ / 1000) * OV_QUAL_NS / 1_000_000;
  localparam int QUAL_CYC = (QUAL_RAW < 1) ? 1 : QUAL_RAW;

  logic            active;
  logic            active_q;
  logic [TH_W-1:0] th_ov, th_upper, th_lower, th_rel, th_trip;
  logic            ovp_off, ls_hold;
  logic            oflp_armed, oflp_trip;

  assign active = enable && supply_ok;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= active;
  end

  ofp_thresh #(.CODE_W(CODE_W)) u_thresh (
    .clk(clk), .rst(rst), .ref_code(ref_code),
    .th_ov(th_ov), .th_upper(th_upper), .th_lower(th_lower),
    .th_rel(th_rel), .th_trip(th_trip)
  );

  ofp_ovp #(.CODE_W(CODE_W), .QUAL_CYC(QUAL_CYC)) u_ovp (
    .clk(clk), .rst(rst), .active(active), .strobe(sample_valid),
    .sense(sense_code), .th_ov(th_ov), .th_lower(th_lower),
    .ovp_off(ovp_off), .ls_hold(ls_hold)
  );

  ofp_oflp #(.CODE_W(CODE_W)) u_oflp (
    .clk(clk), .rst(rst), .active(active), .strobe(sample_valid),
    .sense(sense_code), .fb(fb_code),
    .th_upper(th_upper), .th_lower(th_lower), .th_rel(th_rel), .th_trip(th_trip),
    .armed(oflp_armed), .tripped(oflp_trip)
  );

  assign hs_permit   = active_q && !ovp_off;
  assign ls_force_on = ls_hold;
  assign sw_disable  = oflp_trip;
  assign pg_fault    = ovp_off || oflp_trip;
endmodule

// File: rtl/ofp_ctrl_chk.sv
module ofp_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic supply_ok,
  input logic hs_permit,
  input logic ls_force_on,
  input logic sw_disable,
  input logic pg_fault,
  input logic active_q,
  input logic oflp_armed
);
  p_ls_blocks_hs_r4: assert property (@(posedge clk) disable iff (rst)
    ls_force_on |-> !hs_permit);

  p_hs_drop_flags_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(hs_permit) && active_q) |-> pg_fault);

  p_ls_with_fault_r5: assert property (@(posedge clk) disable iff (rst)
    ls_force_on |-> pg_fault);

  p_latch_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (active_q && $past(active_q) && $past(!hs_permit)) |-> !hs_permit);

  p_trip_after_arm_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_disable) |-> $past(oflp_armed));

  p_inactive_clear_r11: assert property (@(posedge clk) disable iff (rst)
    !(enable && supply_ok) |=> (!hs_permit && !ls_force_on && !sw_disable && !pg_fault));
endmodule

bind ofp_ctrl ofp_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .supply_ok(supply_ok),
  .hs_permit(hs_permit), .ls_force_on(ls_force_on), .sw_disable(sw_disable),
  .pg_fault(pg_fault), .active_q(active_q), .oflp_armed(oflp_armed)
);

// File: tb/tb_ofp_ctrl.sv
module tb_ofp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 12;
  localparam int CLK_HZ     = 10_000_000;   // gives a 20-cycle qualification window
  localparam int QUAL       = 20;
  localparam int NVEC       = 12;
  // {sense, fb, expected sw_disable, expected pg_fault}; ref = 1024
  localparam int VEC [NVEC][4] = '{
    '{800, 700, 0, 0},   // R10 not armed, low fb ignored
    '{871, 900, 0, 0},   // R7 arms
    '{850, 700, 1, 1},   // R8 trip
    '{850, 760, 1, 1},   // R9 not yet above 768
    '{850, 769, 0, 0},   // R9 clears
    '{819, 900, 0, 0},   // R7 disarms at lower threshold
    '{830, 700, 0, 0},   // R7 disarmed, below upper
    '{1228, 700, 0, 0},  // R1 equal to OV threshold, arms
    '{900, 716, 0, 0},   // R1 equal to trip threshold
    '{900, 715, 1, 1},   // R8 trip one code below
    '{900, 768, 1, 1},   // R9 equal to release, stays
    '{900, 800, 0, 0}    // R9 clears
  };

  logic clk = 0, rst = 1, enable = 0, supply_ok = 0, sample_valid = 0;
  logic [CODE_W-1:0] sense_code = '0, fb_code = '0, ref_code = 12'd1024;
  logic hs_permit, ls_force_on, sw_disable, pg_fault;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofp_ctrl #(.CODE_W(CODE_W), .CLK_FREQ_HZ(CLK_HZ), .OV_QUAL_NS(2000)) dut (
    .clk(clk), .rst(rst), .enable(enable), .supply_ok(supply_ok),
    .sample_valid(sample_valid), .sense_code(sense_code), .fb_code(fb_code),
    .ref_code(ref_code), .hs_permit(hs_permit), .ls_force_on(ls_force_on),
    .sw_disable(sw_disable), .pg_fault(pg_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input int s, input int f);
    @(negedge clk);
    sense_code = CODE_W'(s); fb_code = CODE_W'(f); sample_valid = 1;
    @(negedge clk);
    sample_valid = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    chk("R12 hs_permit", hs_permit, 0);
    chk("R12 ls_force_on", ls_force_on, 0);
    chk("R12 sw_disable", sw_disable, 0);
    chk("R12 pg_fault", pg_fault, 0);
    rst = 0;
    wait_cyc(3);
    chk("R11 hs_permit while disabled", hs_permit, 0);
    enable = 1; supply_ok = 1;
    wait_cyc(2);
    chk("R11 hs_permit after enable", hs_permit, 1);

    for (int i = 0; i < NVEC; i++) begin
      strobe(VEC[i][0], VEC[i][1]);
      chk($sformatf("R8/R9 vec%0d sw_disable", i), sw_disable, VEC[i][2]);
      chk($sformatf("R8/R9 vec%0d pg_fault", i), pg_fault, VEC[i][3]);
      chk($sformatf("R1 vec%0d hs_permit", i), hs_permit, 1);
    end
    wait_cyc(QUAL + 10);
    chk("R1 R3 sense equal to OV threshold", hs_permit, 1);

    // R2: unstrobed over-voltage value is ignored
    @(negedge clk); sense_code = 12'd2000; fb_code = 12'd100;
    wait_cyc(50);
    chk("R2 hs_permit", hs_permit, 1);
    chk("R2 sw_disable", sw_disable, 0);

    // R3: window restarts on a non-over sample
    strobe(1229, 900);
    wait_cyc(10);
    strobe(1000, 900);
    wait_cyc(QUAL + 10);
    chk("R3 restart keeps hs_permit", hs_permit, 1);
    strobe(1229, 900);
    wait_cyc(QUAL - 5);
    chk("R3 before window", hs_permit, 1);
    wait_cyc(10);
    chk("R4 hs_permit off", hs_permit, 0);
    chk("R4 ls_force_on", ls_force_on, 1);
    chk("R4 pg_fault", pg_fault, 1);

    // R5: low side held until below lower threshold
    strobe(819, 900);
    chk("R5 ls held at lower", ls_force_on, 1);
    strobe(818, 900);
    chk("R5 ls released", ls_force_on, 0);
    chk("R5 fault kept", pg_fault, 1);
    chk("R6 hs latched", hs_permit, 0);

    // R6: latch cleared by supply cycle, then by enable cycle
    wait_cyc(20); strobe(500, 900);
    chk("R6 hs stays off", hs_permit, 0);
    @(negedge clk); supply_ok = 0;
    wait_cyc(2); supply_ok = 1;
    wait_cyc(3);
    chk("R6 hs after supply cycle", hs_permit, 1);
    chk("R6 fault after supply cycle", pg_fault, 0);
    strobe(1229, 900);
    wait_cyc(QUAL + 5);
    chk("R4 second trip", hs_permit, 0);
    @(negedge clk); enable = 0;
    wait_cyc(2); enable = 1;
    wait_cyc(3);
    chk("R6 hs after enable cycle", hs_permit, 1);

    // R11: disabling clears the armed state
    strobe(900, 900);
    strobe(900, 700);
    chk("R8 trip before disable", sw_disable, 1);
    @(negedge clk); enable = 0;
    wait_cyc(2);
    chk("R11 sw_disable", sw_disable, 0);
    chk("R11 pg_fault", pg_fault, 0);
    chk("R11 hs_permit", hs_permit, 0);
    chk("R11 ls_force_on", ls_force_on, 0);
    enable = 1;
    wait_cyc(3);
    strobe(850, 700);
    chk("R11 armed state cleared", sw_disable, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule